// File: doc/BRIEF.md
# Shared-Timebase Multi-Channel PWM Generator

This block drives a group of pulse-width-modulated outputs that all run on one common timebase. A prescaler divides the input clock into ticks, and an 8-bit tick counter cycles through 256 values to form every PWM period. Each channel compares the counter against its own 8-bit duty code. The output of that channel is high while the counter has not yet passed the code. One global enable starts or stops all channels together.

Software sets the block up through a simple 32-bit register port. Writes are synchronous and reads are combinational. There is one duty register per channel, at byte offset 4×n. The control register at offset 0x50 holds the enable bit and the 8-bit prescaler, which is split across two 4-bit fields. Duty and prescaler writes go into shadow registers. They are copied into the working registers only at a period wrap, or at any time while the block is disabled, so a running period is never cut short.

Top module: `shared_pwm`

## Requirements
- R1: The tick counter steps by one per tick, from 0 up to 255, and then wraps to 0, so every period is exactly 256 ticks.
- R2: With working prescale value P, a tick occurs every P+1 clock cycles, so a period lasts 256×(P+1) cycles.
- R3: The prescaler is 8 bits. Its bits [3:0] are written from control bits [3:0], and its bits [7:4] are written from control bits [14:11].
- R4: A duty code of 0 holds the output high for exactly one tick at the start of each period.
- R5: A duty code of 255 holds the output high for the whole period.
- R6: For any duty code D, the output is high while the counter is ≤ D. This gives (D+1)×(P+1) high cycles per period, starting at the first cycle of the period.
- R7: Control bit 9 is the one enable for all channels. When it is 0, every output is low and the counter and prescaler are held at 0. Setting it starts a fresh period from counter value 0.
- R8: Duty register n is at byte address 4×n and stores 8 bits. The control register is at byte address 0x50. Reads return the stored duty code in bits [7:0], and for the control register they return the enable bit in bit 9 and the prescaler fields in their write positions. All other bits read 0.
- R9: While the block is enabled, a new duty or prescale value takes effect only at the next period wrap.
- R10: After reset, all outputs are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: four channels and an 8-bit address. With prescale 0 a period is only 256 cycles long, so every one of the 256 duty codes can be swept on all four channels in turn. Prescale values 3, 0x10 and 0x12 are short enough to measure whole periods. Between them they cover the low field alone, the high field alone, and both fields together. A duty write made in the middle of a period, and a disable/re-enable sequence, check the wrap-only update and the restart from zero.

// File: rtl/shared_pwm.sv
module shared_pwm #(
  parameter int NCH = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_OFS = AW'('h50)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int EN_BIT = 9;

  logic [NCH-1:0][7:0] duty_sh, duty_nx, duty_act;
  logic [3:0] psc_lo, psc_hi, psc_lo_nx, psc_hi_nx;
  logic       en_q, en_nx;
  logic [7:0] psc_act, pre_q, cnt_q;

  wire ctrl_hit = bus_addr == CTRL_OFS;
  wire tick     = pre_q == psc_act;
  wire wrap     = tick && cnt_q == 8'hFF;
  wire load     = !en_q || wrap;

  always_comb begin
    duty_nx   = duty_sh;
    psc_lo_nx = psc_lo;
    psc_hi_nx = psc_hi;
    en_nx     = en_q;
    if (bus_we) begin
      if (ctrl_hit) begin
        psc_lo_nx = bus_wdata[3:0];
        psc_hi_nx = bus_wdata[14:11];
        en_nx     = bus_wdata[EN_BIT];
      end
      for (int i = 0; i < NCH; i++)
        if (bus_addr == AW'(4 * i)) duty_nx[i] = bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_sh  <= '0;
      duty_act <= '0;
      psc_lo   <= '0;
      psc_hi   <= '0;
      psc_act  <= '0;
      en_q     <= 1'b0;
      pre_q    <= '0;
      cnt_q    <= '0;
    end else begin
      duty_sh <= duty_nx;
      psc_lo  <= psc_lo_nx;
      psc_hi  <= psc_hi_nx;
      en_q    <= en_nx;
      if (load) begin
        duty_act <= duty_nx;
        psc_act  <= {psc_hi_nx, psc_lo_nx};
      end
      if (!en_q) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 8'd1;
      end else begin
        pre_q <= pre_q + 8'd1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit) bus_rdata = {17'b0, psc_hi, 1'b0, en_q, 5'b0, psc_lo};
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(4 * i)) bus_rdata = {24'b0, duty_sh[i]};
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign pwm_out[g] = en_q && (cnt_q <= duty_act[g]);
  end
endmodule

// File: rtl/shared_pwm_chk.sv
module shared_pwm_chk #(
  parameter int NCH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [7:0]          cnt,
  input logic [7:0]          pre,
  input logic [7:0]          psc,
  input logic [NCH-1:0][7:0] duty,
  input logic [NCH-1:0]      out
);
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> (cnt == $past(cnt) || cnt == 8'($past(cnt) + 8'd1)));

  assert_tick_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cnt != $past(cnt)) |-> $past(pre) == $past(psc));

  assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> out == '0);

  assert_off_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (cnt == 8'd0 && pre == 8'd0));

  assert_wrap_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !($past(cnt) == 8'hFF && $past(pre) == $past(psc)))
      |-> ($stable(duty) && $stable(psc)));

  for (genvar g = 0; g < NCH; g++) begin : g_full
    assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && duty[g] == 8'hFF) |-> out[g]);
  end
endmodule

bind shared_pwm shared_pwm_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .cnt(cnt_q), .pre(pre_q),
  .psc(psc_act), .duty(duty_act), .out(pwm_out)
);

// File: tb/shared_pwm_test.sv
module shared_pwm_test;
  localparam int NCH = 4;
  localparam int AW = 8;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_pwm #(.NCH(NCH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  function automatic int ctrl_word(input int p, input bit en);
    return (p & 15) | (((p >> 4) & 15) << 11) | (en ? 32'h200 : 0);
  endfunction

  task automatic run_period(input int p, input int d[NCH], input string req);
    int hi[NCH];
    foreach (hi[c]) hi[c] = 0;
    wr('h50, ctrl_word(p, 0));
    for (int c = 0; c < NCH; c++) wr(4 * c, d[c]);
    wr('h50, ctrl_word(p, 1));
    for (int i = 0; i < 256 * (p + 1); i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi[c]++;
    end
    for (int c = 0; c < NCH; c++)
      chk(hi[c] == (d[c] + 1) * (p + 1), req, hi[c], (d[c] + 1) * (p + 1));
    @(negedge clk);
    chk(pwm_out == '1, "R1 wrap to 0", pwm_out, 15);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int d[NCH];
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R10 reset state
    rd('h50, v); chk(v == 0, "R10 ctrl reset", v, 0);
    rd(0, v); chk(v == 0, "R10 duty reset", v, 0);
    chk(pwm_out == 0, "R10 outputs low", pwm_out, 0);

    // R8 address map and readback
    wr(8, 'h1AB); rd(8, v); chk(v == 'hAB, "R8 duty readback", v, 'hAB);
    wr(4, 'h33); rd(4, v); chk(v == 'h33, "R8 duty ch1", v, 'h33);
    wr('h50, 32'hFFFF_FFFF); rd('h50, v); chk(v == 'h7A0F, "R8 ctrl readback", v, 'h7A0F);
    wr('h50, 0); rd('h50, v); chk(v == 0, "R8 ctrl cleared", v, 0);

    // R6 R4 R5 exhaustive duty sweep, prescale 0
    for (int k = 0; k < 256; k++) begin
      d[0] = k; d[1] = 255 - k; d[2] = k ^ 'h55; d[3] = (k * 7) & 255;
      run_period(0, d, "R6 high width");
    end
    d = '{0, 127, 255, 40};
    run_period(0, d, "R4 R5 edge codes");

    // R2 R3 prescaler split fields
    run_period(3, d, "R2 R3 low field");
    run_period('h10, d, "R2 R3 high field");
    run_period('h12, d, "R2 R3 both fields");

    // R9 mid-period duty write waits for wrap
    begin
      int h0 = 0, h1 = 0;
      wr('h50, 0); wr(0, 10);
      wr('h50, 'h200);
      for (int i = 0; i < 512; i++) begin
        @(negedge clk);
        bus_we = 0;
        if (pwm_out[0]) begin if (i < 256) h0++; else h1++; end
        if (i == 50) begin bus_we = 1; bus_addr = 0; bus_wdata = 200; end
      end
      chk(h0 == 11, "R9 old duty holds", h0, 11);
      chk(h1 == 201, "R9 new duty at wrap", h1, 201);
    end

    // R7 global disable and restart
    begin
      int h = 0;
      bit any = 0;
      for (int c = 0; c < NCH; c++) wr(4 * c, 255);
      repeat (300) @(negedge clk);
      wr('h50, 0);
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out != 0) any = 1; end
      chk(!any, "R7 disabled outputs low", any, 0);
      wr(0, 5);
      wr('h50, 'h200);
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        if (i == 0) chk(pwm_out[0], "R7 restart at counter 0", pwm_out[0], 1);
        if (pwm_out[0]) h++;
      end
      chk(h == 6, "R7 restart width", h, 6);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule